// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block holds a small bank of list registers, one virtual interrupt per entry. Each entry carries an interrupt ID, an 8-bit priority, a group bit and pending and active state bits. A separate selector outside the block supplies the index of the highest-priority pending entry. From that entry, the interface enable, a priority mask, two binary point values and a shared-binary-point control, the unit decides whether the entry may be signalled. It then drives a virtual FIQ line for group 0 or a virtual IRQ line for group 1.

A guest reads an acknowledge for group 0 or group 1 through a valid/ready request channel. The unit answers with an interrupt ID on a response strobe one cycle later. The response cannot be stalled, so the consumer must always take it. When an acknowledge is accepted, `ack_ready` drops for one cycle so that the interrupt lines can be re-evaluated before the next request. An accepted acknowledge moves the entry from pending to active and sets one bit in the active-priority bit set of the acknowledging group. The lowest set bit across both groups gives the running priority, which later preemption decisions compare against. A load port lets the hypervisor side replace any entry.

Top module: `vintr_ack_unit`

## Requirements
- R1: While `vif_en` is low, `virq` and `vfiq` are low from the next cycle, and every accepted acknowledge returns ID 1023.
- R2: An entry is signallable only when its priority is strictly below `pri_mask`. A priority equal to or above the mask blocks it.
- R3: The running priority is the index of the lowest set active-priority bit in either group, shifted left by 8−PREBITS. With no bit set it is 0xFF, and any unmasked pending entry is then signallable.
- R4: For group 0, the group mask is 0xFF shifted left by `bpoint0`+1, so a value of 7 leaves no group-priority bits.
- R5: For group 1 with `share_bpoint` low, `bpoint1` is raised to 1 if it is 0 and then reduced by one before the R4 rule. A value of 7 keeps only bit 7. With `share_bpoint` high, group 1 uses `bpoint0` unchanged.
- R6: While something is active, an entry preempts only if (priority & mask) is strictly less than (running priority & mask), using the mask of the entry's group.
- R7: A signallable group 0 entry (group bit 0) raises `vfiq`, and a group 1 entry (group bit 1) raises `virq`. Both lines are registered one cycle after their inputs, and at most one is high.
- R8: An acknowledge of the other group, or with nothing signallable, returns 1023 and changes no state.
- R9: An acknowledge of an ID below 1020 clears the entry's pending bit and sets its active bit. It also sets bit ((priority & mask) >> (8−PREBITS)) of that group's active-priority set.
- R10: An acknowledge of an ID of 1020 or above clears only the pending bit, sets no active-priority bit, and returns that ID.
- R11: A request is accepted when `ack_valid` and `ack_ready` are both high. `rsp_valid` pulses one cycle later with the ID, and `ack_ready` is low for the cycle after an acceptance. `ack_ready` is high out of reset.
- R12: `lr_load` replaces entry `lr_load_idx` at the next edge. It takes precedence over an acknowledge update of the same entry in the same cycle.
- R13: No entry is signallable unless `hp_valid` is high and the selected entry's pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vif_en | input | 1 | Virtual interface enable |
| pri_mask | input | 8 | Priority mask |
| bpoint0 | input | 3 | Group 0 binary point |
| bpoint1 | input | 3 | Group 1 binary point (minimum 1) |
| share_bpoint | input | 1 | Group 1 uses the group 0 binary point |
| hp_valid | input | 1 | Highest pending index is valid |
| hp_idx | input | IDX_W | Index of highest pending entry |
| lr_load | input | 1 | Load strobe for one entry |
| lr_load_idx | input | IDX_W | Entry to load |
| lr_load_id | input | 10 | Interrupt ID to load |
| lr_load_prio | input | 8 | Priority to load |
| lr_load_grp | input | 1 | Group to load |
| lr_load_pend | input | 1 | Pending bit to load |
| lr_load_act | input | 1 | Active bit to load |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_grp | input | 1 | Group being acknowledged |
| ack_ready | output | 1 | Acknowledge request can be accepted |
| rsp_valid | output | 1 | Acknowledge response strobe |
| rsp_id | output | 10 | Acknowledged or spurious ID |
| virq | output | 1 | Virtual IRQ level |
| vfiq | output | 1 | Virtual FIQ level |

## Verification
The assertions assume that `hp_idx` names an existing entry whenever `hp_valid` is high. They also assume that the acknowledge consumer always takes the response, since the response channel has no ready. The bench changes inputs only on falling edges and raises `ack_valid` only while `ack_ready` is high. Its near-exhaustive sweep covers every pair of binary points, both sharing settings and both groups for the active and the pending entry. A reset before each point keeps the active-priority state equal to the bench's arithmetic model.

// File: rtl/vack_pkg.sv
package vack_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0]   ID_SPURIOUS     = 10'd1023;
  localparam logic [ID_W-1:0]   ID_SPECIAL_BASE = 10'd1020;
  localparam logic [PRIO_W-1:0] PRIO_IDLE       = 8'hFF;

  typedef enum logic {GRP0 = 1'b0, GRP1 = 1'b1} grp_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
    grp_e              grp;
    logic              pend;
    logic              act;
  } lr_entry_t;

  // Group-priority mask for one group from the binary point settings.
  function automatic logic [PRIO_W-1:0] grp_mask(grp_e g, logic [2:0] bp0,
                                                 logic [2:0] bp1, logic share);
    logic [3:0] n;
    logic [PRIO_W-1:0] ones;
    ones = '1;
    if (g == GRP1 && !share) begin
      n = (bp1 == 3'd0) ? 4'd0 : {1'b0, bp1 - 3'd1};
    end else begin
      n = {1'b0, bp0};
    end
    return ones << (n + 4'd1);
  endfunction
endpackage

// File: rtl/vack_lr_bank.sv
module vack_lr_bank import vack_pkg::*; #(
  parameter int NUM_LR = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  lr_entry_t               wr_data,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  input  logic                    upd_activate,
  output lr_entry_t [NUM_LR-1:0]  lr_q
);
  for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
    lr_entry_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ent_q <= wr_data;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        ent_q.pend <= 1'b0;
        if (upd_activate) ent_q.act <= 1'b1;
      end
    end
    assign lr_q[i] = ent_q;
  end
endmodule

// File: rtl/vack_apr_file.sv
module vack_apr_file #(
  parameter int PREBITS = 5,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               set_grp,
  input  logic [PREBITS-1:0] set_bit,
  output logic [PRIO_W-1:0]  run_prio
);
  localparam int NB     = 1 << PREBITS;
  localparam int NWORDS = NB / 32;
  localparam int SH     = PRIO_W - PREBITS;

  logic [NB-1:0] g0_bits, g1_bits, any_bits;
  logic [PREBITS-1:0] low_idx;
  logic found;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [31:0] w0_q, w1_q;
    logic hit;
    assign hit = set_en && ((set_bit >> 5) == PREBITS'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w0_q <= '0;
        w1_q <= '0;
      end else if (hit) begin
        if (set_grp) w1_q[set_bit[4:0]] <= 1'b1;
        else         w0_q[set_bit[4:0]] <= 1'b1;
      end
    end
    assign g0_bits[w*32 +: 32] = w0_q;
    assign g1_bits[w*32 +: 32] = w1_q;
  end

  assign any_bits = g0_bits | g1_bits;

  always_comb begin
    found   = 1'b0;
    low_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (any_bits[i]) begin
        found   = 1'b1;
        low_idx = PREBITS'(i);
      end
    end
    run_prio = found ? (PRIO_W'(low_idx) << SH) : '1;
  end
endmodule

// File: rtl/vack_eval.sv
module vack_eval import vack_pkg::*; (
  input  lr_entry_t          entry,
  input  logic               hp_valid,
  input  logic               en,
  input  logic [PRIO_W-1:0]  pmask,
  input  logic [PRIO_W-1:0]  run_prio,
  input  logic [2:0]         bp0,
  input  logic [2:0]         bp1,
  input  logic               share,
  output logic               can_signal,
  output logic [PRIO_W-1:0]  gmask
);
  always_comb begin
    gmask      = grp_mask(entry.grp, bp0, bp1, share);
    can_signal = 1'b0;
    if (en && hp_valid && entry.pend && (entry.prio < pmask)) begin
      if (run_prio == PRIO_IDLE) can_signal = 1'b1;
      else can_signal = (entry.prio & gmask) < (run_prio & gmask);
    end
  end
endmodule

// File: rtl/vintr_ack_unit.sv
module vintr_ack_unit import vack_pkg::*; #(
  parameter int NUM_LR  = 4,
  parameter int PREBITS = 5,
  localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vif_en,
  input  logic [7:0]       pri_mask,
  input  logic [2:0]       bpoint0,
  input  logic [2:0]       bpoint1,
  input  logic             share_bpoint,
  input  logic             hp_valid,
  input  logic [IDX_W-1:0] hp_idx,
  input  logic             lr_load,
  input  logic [IDX_W-1:0] lr_load_idx,
  input  logic [9:0]       lr_load_id,
  input  logic [7:0]       lr_load_prio,
  input  logic             lr_load_grp,
  input  logic             lr_load_pend,
  input  logic             lr_load_act,
  input  logic             ack_valid,
  input  logic             ack_grp,
  output logic             ack_ready,
  output logic             rsp_valid,
  output logic [9:0]       rsp_id,
  output logic             virq,
  output logic             vfiq
);
  localparam int SH = PRIO_W - PREBITS;

  lr_entry_t [NUM_LR-1:0] lr_q;
  lr_entry_t cur, load_ent;
  logic [PRIO_W-1:0] run_prio, gmask;
  logic can_sig, accept, hit, normal_id, hold_q;
  logic [PREBITS-1:0] apr_bit;

  assign load_ent = '{id: lr_load_id, prio: lr_load_prio, grp: grp_e'(lr_load_grp),
                      pend: lr_load_pend, act: lr_load_act};
  assign cur      = (int'(hp_idx) < NUM_LR) ? lr_q[hp_idx] : '0;

  vack_eval u_eval (
    .entry(cur), .hp_valid(hp_valid), .en(vif_en), .pmask(pri_mask),
    .run_prio(run_prio), .bp0(bpoint0), .bp1(bpoint1), .share(share_bpoint),
    .can_signal(can_sig), .gmask(gmask)
  );

  assign ack_ready = !hold_q;
  assign accept    = ack_valid && ack_ready;
  assign hit       = accept && can_sig && (cur.grp == grp_e'(ack_grp));
  assign normal_id = cur.id < ID_SPECIAL_BASE;
  assign apr_bit   = PREBITS'((cur.prio & gmask) >> SH);

  vack_lr_bank #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(lr_load), .wr_idx(lr_load_idx),
    .wr_data(load_ent), .upd_en(hit), .upd_idx(hp_idx),
    .upd_activate(normal_id), .lr_q(lr_q)
  );

  vack_apr_file #(.PREBITS(PREBITS), .PRIO_W(PRIO_W)) u_apr (
    .clk(clk), .rst_n(rst_n), .set_en(hit && normal_id), .set_grp(ack_grp),
    .set_bit(apr_bit), .run_prio(run_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_id    <= ID_SPURIOUS;
      virq      <= 1'b0;
      vfiq      <= 1'b0;
    end else begin
      hold_q    <= accept;
      rsp_valid <= accept;
      if (accept) rsp_id <= hit ? cur.id : ID_SPURIOUS;
      virq      <= can_sig && (cur.grp == GRP1);
      vfiq      <= can_sig && (cur.grp == GRP0);
    end
  end
endmodule

// File: rtl/vintr_ack_chk.sv
module vintr_ack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vif_en,
  input logic [7:0] pri_mask,
  input logic       hp_valid,
  input logic       ack_valid,
  input logic       ack_ready,
  input logic       rsp_valid,
  input logic [9:0] rsp_id,
  input logic       virq,
  input logic       vfiq
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vif_en |=> (!virq && !vfiq));
  assert_idle_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && !vif_en) |=> (rsp_id == 10'd1023));
  assert_zero_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mask == 8'd0) |=> (!virq && !vfiq));
  assert_one_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({virq, vfiq}));
  assert_no_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && !hp_valid) |=> (rsp_id == 10'd1023));
  assert_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> (rsp_valid && !ack_ready));
  assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && ack_ready) |=> !rsp_valid);
  assert_no_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_valid |=> (!virq && !vfiq));
endmodule

bind vintr_ack_unit vintr_ack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vif_en(vif_en), .pri_mask(pri_mask),
  .hp_valid(hp_valid), .ack_valid(ack_valid), .ack_ready(ack_ready),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .virq(virq), .vfiq(vfiq)
);

// File: tb/tb_vintr_ack_unit.sv
module tb_vintr_ack_unit;
  localparam int CLK_P = 10;
  localparam int SH    = 3;  // 8 - PREBITS with default PREBITS = 5

  logic clk = 1'b0, rst_n = 1'b0;
  logic vif_en, share_bpoint, hp_valid, lr_load, lr_load_grp, lr_load_pend, lr_load_act;
  logic [7:0] pri_mask, lr_load_prio;
  logic [2:0] bpoint0, bpoint1;
  logic [1:0] hp_idx, lr_load_idx;
  logic [9:0] lr_load_id, rsp_id;
  logic ack_valid, ack_grp, ack_ready, rsp_valid, virq, vfiq;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_apr0, m_apr1;

  always #(CLK_P/2) clk = ~clk;

  vintr_ack_unit dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mask(bit g);
    logic [3:0] n;
    if (g && !share_bpoint) n = (bpoint1 == 0) ? 4'd0 : {1'b0, bpoint1 - 3'd1};
    else n = {1'b0, bpoint0};
    return 8'hFF << (n + 4'd1);
  endfunction

  function automatic logic [7:0] m_rprio();
    for (int i = 0; i < 32; i++)
      if (m_apr0[i] || m_apr1[i]) return 8'(i << SH);
    return 8'hFF;
  endfunction

  function automatic bit m_sig(logic [7:0] p, bit g, bit pend);
    logic [7:0] r, m;
    r = m_rprio();
    m = m_mask(g);
    if (!(vif_en && hp_valid && pend && p < pri_mask)) return 0;
    if (r == 8'hFF) return 1;
    return (p & m) < (r & m);
  endfunction

  task automatic do_reset();
    rst_n = 0; vif_en = 0; share_bpoint = 0; hp_valid = 0; lr_load = 0;
    lr_load_grp = 0; lr_load_pend = 0; lr_load_act = 0; pri_mask = 8'hFF;
    lr_load_prio = 0; bpoint0 = 0; bpoint1 = 1; hp_idx = 0; lr_load_idx = 0;
    lr_load_id = 0; ack_valid = 0; ack_grp = 0;
    m_apr0 = 0; m_apr1 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load(input int idx, input int id, input int prio, input bit g, input bit pend);
    lr_load = 1; lr_load_idx = 2'(idx); lr_load_id = 10'(id); lr_load_prio = 8'(prio);
    lr_load_grp = g; lr_load_pend = pend; lr_load_act = 0;
    @(negedge clk);
    lr_load = 0;
    @(negedge clk);
  endtask

  task automatic do_ack(input bit g, output int id, output bit rv, output bit rdy);
    ack_grp = g; ack_valid = 1;
    @(negedge clk);
    rv = rsp_valid; id = int'(rsp_id); rdy = ack_ready;
    ack_valid = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    int id;
    bit rv, rdy;
    do_reset();
    // Reset state (R11, R7)
    chk(virq == 0 && vfiq == 0, "R7 reset lines", int'({virq, vfiq}), 0);
    chk(rsp_valid == 0, "R11 reset rsp_valid", int'(rsp_valid), 0);
    chk(ack_ready == 1, "R11 reset ack_ready", int'(ack_ready), 1);

    // R1: disabled interface
    load(0, 33, 8'h40, 1, 1);
    hp_valid = 1; hp_idx = 0; settle();
    chk(virq == 0, "R1 disabled no virq", int'(virq), 0);
    do_ack(1, id, rv, rdy);
    chk(id == 1023, "R1 disabled ack spurious", id, 1023);
    vif_en = 1; settle();
    chk(virq == 1 && vfiq == 0, "R1/R7 enabled group1 virq", int'({virq, vfiq}), 2);

    // R2: priority mask boundary
    pri_mask = 8'h40; settle();
    chk(virq == 0, "R2 prio equal to mask blocked", int'(virq), 0);
    pri_mask = 8'h41; settle();
    chk(virq == 1, "R2 prio below mask signals", int'(virq), 1);
    pri_mask = 8'hFF;

    // R13: pending bit and index valid
    hp_valid = 0; settle();
    chk(virq == 0, "R13 hp_valid low", int'(virq), 0);
    hp_valid = 1;
    load(0, 33, 8'h40, 1, 0);
    chk(virq == 0, "R13 not pending", int'(virq), 0);

    // R7: group 0 drives FIQ
    load(0, 34, 8'h40, 0, 1);
    chk(vfiq == 1 && virq == 0, "R7 group0 vfiq", int'({virq, vfiq}), 1);

    // R8: wrong group acknowledge leaves state
    do_ack(1, id, rv, rdy);
    chk(id == 1023, "R8 wrong group spurious", id, 1023);
    chk(rv == 1 && rdy == 0, "R11 rsp strobe and ready drop", int'({rv, rdy}), 2);
    chk(vfiq == 1, "R8 entry still signalled", int'(vfiq), 1);
    chk(ack_ready == 1, "R11 ready restored", int'(ack_ready), 1);

    // R10: special ID
    load(0, 1021, 8'h20, 1, 1);
    do_ack(1, id, rv, rdy);
    chk(id == 1021, "R10 special ID returned", id, 1021);
    chk(virq == 0, "R10 pending cleared", int'(virq), 0);
    load(1, 60, 8'hF0, 1, 1);
    hp_idx = 1; settle();
    chk(virq == 1, "R10 no active priority set", int'(virq), 1);

    // R12: load beats acknowledge update on same entry
    do_reset();
    vif_en = 1;
    load(0, 50, 8'h30, 0, 1);
    hp_valid = 1; hp_idx = 0; settle();
    lr_load = 1; lr_load_idx = 0; lr_load_id = 51; lr_load_prio = 8'h10;
    lr_load_grp = 0; lr_load_pend = 1; lr_load_act = 0;
    ack_grp = 0; ack_valid = 1;
    @(negedge clk);
    id = int'(rsp_id);
    lr_load = 0; ack_valid = 0;
    chk(id == 50, "R12 ack returns old ID", id, 50);
    @(negedge clk);
    chk(vfiq == 1, "R12 loaded entry kept pending", int'(vfiq), 1);
    do_ack(0, id, rv, rdy);
    chk(id == 51, "R12 loaded ID acknowledged", id, 51);

    // Sweep: R3 R4 R5 R6 R9
    for (int b0 = 0; b0 < 8; b0++)
      for (int b1 = 0; b1 < 8; b1++)
        for (int c = 0; c < 2; c++)
          for (int ga = 0; ga < 2; ga++) begin
            logic [7:0] pa, ma;
            do_reset();
            vif_en = 1; bpoint0 = 3'(b0); bpoint1 = 3'(b1); share_bpoint = c[0];
            pa = 8'h6C;
            load(0, 32, pa, ga[0], 1);
            hp_valid = 1; hp_idx = 0; settle();
            do_ack(ga[0], id, rv, rdy);
            chk(id == 32, "R9 ack returns ID", id, 32);
            ma = m_mask(ga[0]);
            if (ga[0]) m_apr1[(pa & ma) >> SH] = 1'b1;
            else       m_apr0[(pa & ma) >> SH] = 1'b1;
            chk(virq == 0 && vfiq == 0, "R9 acknowledged entry no longer pending",
                int'({virq, vfiq}), 0);
            for (int q = 0; q < 32; q++) begin
              logic [7:0] pq;
              bit gq, exp;
              pq = 8'((q << 3) | (q & 7));
              gq = q[0] ^ q[3];
              load(1, 64 + q, pq, gq, 1);
              hp_idx = 1; settle();
              exp = m_sig(pq, gq, 1);
              chk(virq == (exp && gq) && vfiq == (exp && !gq),
                  "R3/R4/R5/R6 preemption", int'({virq, vfiq}),
                  int'({exp && gq, exp && !gq}));
            end
          end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule